// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic core of a small 8-bit processor. It holds an accumulator (A), a second register (B) and an 8-bit status word, and it performs one operation per request taken from a valid/ready command port. Add, add-with-carry, subtract-with-borrow and increment finish in one cycle. Unsigned multiply and unsigned divide run on an iterative unit for four cycles. During that time the command port refuses new work.

Each arithmetic operation rewrites the carry, auxiliary-carry and overflow flags. The parity bit is not stored. It is derived from A at all times, so it follows every change to the accumulator, including plain loads. Software can write the status word directly, including the two register-bank select bits and the general flags. Each finished operation produces a one-cycle `res_valid` pulse that carries the new value of A.

Command port rules:
- A command transfers on a rising edge where `op_valid` and `op_ready` are both high.
- `op_valid` may stay high across cycles.
- `op_ready` is low from the cycle after a multiply or divide is accepted until its result is committed.
- The result side has no back-pressure. The consumer must take `res_valid` in the cycle it appears.

Top module: `acc_alu`

## Requirements
- R1: After reset, A, B and the status word are 0, `op_ready` is 1 and `res_valid` is 0.
- R2: Operation codes: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment A, 4 multiply, 5 divide, 6 load A from `op_data`, 7 load B from `op_data`. A single-cycle command accepted on edge N raises `res_valid` for the cycle after edge N, and `result` then equals the new A.
- R3: A multiply or divide accepted on edge N drops `op_ready` after edge N. It commits on edge N+4, raises `res_valid` for the cycle after that edge, and restores `op_ready`.
- R4: Add (op 0) and add-with-carry (op 2's counterpart, op 1; carry-in is bit 7) set bit 7 (CY) on a carry out of bit 7. They set bit 6 (AC) on a carry out of bit 3. They set bit 2 (OV) when the signed sum leaves the range -128 to 127.
- R5: Subtract-with-borrow computes A - op_data - CY. It sets CY on a borrow, AC on a borrow out of the low nibble, and OV when the signed difference leaves the range -128 to 127.
- R6: Increment adds 1 to A, ignores `op_data`, and updates CY, AC and OV exactly as an add of 1 without carry-in would.
- R7: Multiply puts the low byte of the unsigned product A*B in A and the high byte in B. It clears CY, sets OV when the product exceeds FFh, and leaves AC unchanged.
- R8: Divide puts the quotient of A/B in A and the remainder in B, and clears OV. With B equal to 0 it sets OV and leaves A and B unchanged. Divide always clears CY and leaves AC unchanged.
- R9: Status bit 0 is always the even parity of A: the count of ones in A plus bit 0 is even.
- R10: `psw_wr` loads status bits 7..1 from `psw_wdata`. The bank-select bits 4..3 change only on such a write. If a write coincides with an operation commit, the operation's CY, AC and OV win, the write supplies the other bits, and add-with-carry uses the carry held before that edge.
- R11: Loading A or B changes no status bit other than parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command request |
| op_ready | output | 1 | Command can be taken |
| op_sel | input | 3 | Operation code |
| op_data | input | 8 | Operand byte |
| psw_wr | input | 1 | Direct status-word write strobe |
| psw_wdata | input | 7 | Value for status bits 7..1 |
| res_valid | output | 1 | One-cycle result pulse |
| result | output | 8 | New A value, valid with `res_valid` |
| acc | output | 8 | Accumulator A |
| breg | output | 8 | Register B |
| psw | output | 8 | Status word, parity in bit 0 |

## Verification
The assertions assume that `op_valid` is only acted on while `op_ready` is high. They do not try to cover commands held through a multiply or divide. The latency checks assume that no second command is offered before the previous result pulse. The stimulus follows this: it offers each command only after observing the previous `res_valid`. Directed status writes, some coinciding with a command, are mixed with seeded random operation codes, operands and register contents, including zero divisors and values near the signed and unsigned limits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_INC  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_LDA  = 3'd6,
    OP_LDB  = 3'd7
  } alu_op_e;

  localparam int SW_CY  = 7;
  localparam int SW_AC  = 6;
  localparam int SW_RS1 = 4;
  localparam int SW_RS0 = 3;
  localparam int SW_OV  = 2;
  localparam int SW_PAR = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output arith_flags_t  flags
);
  localparam int HALF = DW / 2;

  logic [DW:0] full;

  always_comb begin
    if (sub) full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    else     full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    sum = full[DW-1:0];
    flags.cy = full[DW];
    // carry or borrow into bit HALF, recovered from the sum bit
    flags.ac = a[HALF] ^ b[HALF] ^ full[HALF];
    if (sub) flags.ov = (a[DW-1] != b[DW-1]) && (full[DW-1] != a[DW-1]);
    else     flags.ov = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int DW  = 8,
  parameter int BPS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_div,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          ovf,
  output logic          hold_ab
);
  localparam int STEPS = DW / BPS;
  localparam int CW    = $clog2(STEPS + 1);

  logic          mode_div;
  logic [CW-1:0] cnt;
  logic [2*DW-1:0] prod, mcand;
  logic [DW-1:0]   mplier;
  logic [DW-1:0]   rem, dvd, dsr;
  logic            dz;

  logic [2*DW-1:0] p_n, mc_n;
  logic [DW-1:0]   mp_n, r_n, q_n;
  logic [DW:0]     t;
  logic            last;

  always_comb begin
    p_n  = prod;
    mc_n = mcand;
    mp_n = mplier;
    for (int i = 0; i < BPS; i++) begin
      if (mp_n[0]) p_n = p_n + mc_n;
      mc_n = mc_n << 1;
      mp_n = mp_n >> 1;
    end
    r_n = rem;
    q_n = dvd;
    t   = '0;
    for (int i = 0; i < BPS; i++) begin
      t   = {r_n, q_n[DW-1]};
      q_n = q_n << 1;
      if (t >= {1'b0, dsr}) begin
        t      = t - {1'b0, dsr};
        q_n[0] = 1'b1;
      end
      r_n = t[DW-1:0];
    end
  end

  assign last    = busy && (cnt == CW'(STEPS - 1));
  assign done    = last;
  assign res_lo  = mode_div ? q_n : p_n[DW-1:0];
  assign res_hi  = mode_div ? r_n : p_n[2*DW-1:DW];
  assign ovf     = mode_div ? dz : (|p_n[2*DW-1:DW]);
  assign hold_ab = mode_div && dz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_div <= 1'b0;
      cnt      <= '0;
      prod     <= '0;
      mcand    <= '0;
      mplier   <= '0;
      rem      <= '0;
      dvd      <= '0;
      dsr      <= '0;
      dz       <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      mode_div <= is_div;
      cnt      <= '0;
      prod     <= '0;
      mcand    <= {{DW{1'b0}}, a_in};
      mplier   <= b_in;
      rem      <= '0;
      dvd      <= a_in;
      dsr      <= b_in;
      dz       <= (b_in == '0);
    end else if (busy) begin
      prod   <= p_n;
      mcand  <= mc_n;
      mplier <= mp_n;
      rem    <= r_n;
      dvd    <= q_n;
      cnt    <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R3
endmodule

// File: rtl/acc_alu_psw.sv
module acc_alu_psw
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] acc_val,
  input  logic          wr_en,
  input  logic [7:1]    wdata,
  input  logic          upd_en,
  input  logic          upd_ac_en,
  input  arith_flags_t  upd,
  output logic [7:0]    psw_out
);
  logic [7:1] held, held_n;

  always_comb begin
    held_n = held;
    if (wr_en) held_n = wdata;
    if (upd_en) begin
      held_n[SW_CY] = upd.cy;
      held_n[SW_OV] = upd.ov;
      if (upd_ac_en) held_n[SW_AC] = upd.ac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_n;
  end

  assign psw_out = {held, ^acc_val};

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(psw_out[SW_RS1:SW_RS0])); // R10
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int BPS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_sel,
  input  logic [DW-1:0] op_data,
  input  logic          psw_wr,
  input  logic [7:1]    psw_wdata,
  output logic          res_valid,
  output logic [DW-1:0] result,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] breg,
  output logic [7:0]    psw
);
  localparam int STEPS = DW / BPS;
  localparam int CW    = $clog2(STEPS + 1);

  alu_op_e op;
  logic accept, is_md, single_commit;
  logic [DW-1:0] acc_q, b_q, acc_n, b_n, res_q;
  logic vld_q;

  logic [DW-1:0] as_b, as_sum;
  logic as_cin, as_sub;
  arith_flags_t as_flags, upd;
  logic upd_en, upd_ac_en;

  logic md_busy, md_done, md_ovf, md_hold;
  logic [DW-1:0] md_lo, md_hi;
  logic [CW-1:0] lat_cnt;

  assign op       = alu_op_e'(op_sel);
  assign op_ready = !md_busy;
  assign accept   = op_valid && op_ready;
  assign is_md    = (op == OP_MUL) || (op == OP_DIV);
  assign single_commit = accept && !is_md;

  assign as_b   = (op == OP_INC) ? DW'(1) : op_data;
  assign as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) ? psw[SW_CY] : 1'b0;
  assign as_sub = (op == OP_SUBB);

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a(acc_q), .b(as_b), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .flags(as_flags)
  );

  acc_alu_muldiv #(.DW(DW), .BPS(BPS)) u_muldiv (
    .clk(clk), .rst_n(rst_n),
    .start(accept && is_md), .is_div(op == OP_DIV),
    .a_in(acc_q), .b_in(b_q),
    .busy(md_busy), .done(md_done),
    .res_lo(md_lo), .res_hi(md_hi), .ovf(md_ovf), .hold_ab(md_hold)
  );

  always_comb begin
    acc_n     = acc_q;
    b_n       = b_q;
    upd_en    = 1'b0;
    upd_ac_en = 1'b0;
    upd       = as_flags;
    if (md_done) begin
      if (!md_hold) begin
        acc_n = md_lo;
        b_n   = md_hi;
      end
      upd_en = 1'b1;
      upd.cy = 1'b0;
      upd.ov = md_ovf;
    end else if (single_commit) begin
      case (op)
        OP_ADD, OP_ADDC, OP_SUBB, OP_INC: begin
          acc_n     = as_sum;
          upd_en    = 1'b1;
          upd_ac_en = 1'b1;
        end
        OP_LDA:  acc_n = op_data;
        OP_LDB:  b_n   = op_data;
        default: ;
      endcase
    end
  end

  acc_alu_psw #(.DW(DW)) u_psw (
    .clk(clk), .rst_n(rst_n), .acc_val(acc_q),
    .wr_en(psw_wr), .wdata(psw_wdata),
    .upd_en(upd_en), .upd_ac_en(upd_ac_en), .upd(upd),
    .psw_out(psw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      b_q   <= b_n;
      vld_q <= single_commit || md_done;
      if (single_commit || md_done) res_q <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (accept)     lat_cnt <= '0;
    else if (md_busy)    lat_cnt <= lat_cnt + 1'b1;
  end

  assign acc       = acc_q;
  assign breg      = b_q;
  assign result    = res_q;
  assign res_valid = vld_q;

  AST_SINGLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    single_commit |=> res_valid); // R2
  AST_MD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_md) |=> !op_ready); // R3
  AST_MD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    md_done |-> (lat_cnt == CW'(STEPS - 1))); // R3
  AST_MD_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    md_done |=> !psw[SW_CY]); // R7
  AST_DIVZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (md_done && md_hold) |=> (acc == $past(acc)) && (breg == $past(breg))); // R8
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] op_data = '0;
  logic psw_wr = 1'b0;
  logic [7:1] psw_wdata = '0;
  logic op_ready, res_valid;
  logic [7:0] result, acc, breg, psw;

  int checks = 0;
  int fails = 0;
  logic [7:0] mA = 0, mB = 0;
  logic [7:1] mS = 0;

  always #2 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .op_data(op_data), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
    .res_valid(res_valid), .result(result), .acc(acc), .breg(breg), .psw(psw)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input logic [7:0] v);
    return (v > 127) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic run_op(input logic [2:0] sel, input logic [7:0] d,
                        input bit wr, input logic [7:1] wd);
    int a, b, c, r, n, lat, sr;
    logic [7:0] eA, eB, eP;
    logic [7:1] eS;
    string tag;
    a = mA; b = mB; c = mS[7];
    eA = mA; eB = mB; eS = wr ? wd : mS;
    lat = 0;
    case (sel)
      3'd0, 3'd1, 3'd3: begin
        tag = (sel == 3'd3) ? "R6" : "R4";
        if (sel == 3'd3) begin b = 1; c = 0; end
        else begin b = d; if (sel == 3'd0) c = 0; end
        r = a + b + c;
        sr = sgn(a[7:0]) + sgn(b[7:0]) + c;
        eA = r[7:0];
        eS[7] = r > 255;
        eS[6] = ((a & 15) + (b & 15) + c) > 15;
        eS[2] = (sr < -128) || (sr > 127);
      end
      3'd2: begin
        tag = "R5";
        b = d;
        r = a - b - c;
        sr = sgn(a[7:0]) - sgn(b[7:0]) - c;
        eA = r[7:0];
        eS[7] = r < 0;
        eS[6] = ((a & 15) - (b & 15) - c) < 0;
        eS[2] = (sr < -128) || (sr > 127);
      end
      3'd4: begin
        tag = "R7"; lat = 4;
        r = a * b;
        eA = r[7:0]; eB = r[15:8];
        eS[7] = 1'b0; eS[2] = r > 255;
      end
      3'd5: begin
        tag = "R8"; lat = 4;
        eS[7] = 1'b0;
        if (b == 0) eS[2] = 1'b1;
        else begin eA = 8'(a / b); eB = 8'(a % b); eS[2] = 1'b0; end
      end
      3'd6: begin tag = "R11"; eA = d; end
      default: begin tag = "R11"; eB = d; end
    endcase
    eP = {eS, ^eA};

    @(negedge clk);
    chk("R2 ready before command", op_ready, 1);
    op_valid = 1'b1; op_sel = sel; op_data = d; psw_wr = wr; psw_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; psw_wr = 1'b0; op_data = $urandom;
    if (lat != 0) chk("R3 ready low while busy", op_ready, 0);
    n = 0;
    while (!res_valid && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk({(lat != 0) ? "R3" : "R2", " latency"}, n, lat);
    chk({"R2 result ", tag}, result, eA);
    chk({tag, " A"}, acc, eA);
    chk({tag, " B"}, breg, eB);
    chk({tag, " R9 R10 status"}, psw, eP);
    mA = eA; mB = eB; mS = eS;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 A", acc, 0);
    chk("R1 B", breg, 0);
    chk("R1 status", psw, 0);
    chk("R1 ready", op_ready, 1);
    chk("R1 res_valid", res_valid, 0);

    run_op(3'd6, 8'h7F, 0, 0);   // R11 load, parity
    run_op(3'd0, 8'h01, 0, 0);   // R4 signed overflow and AC
    run_op(3'd6, 8'hFF, 0, 0);
    run_op(3'd0, 8'h01, 0, 0);   // R4 carry out, zero
    run_op(3'd1, 8'h0F, 0, 0);   // R4 add with carry in
    run_op(3'd6, 8'h80, 0, 0);
    run_op(3'd2, 8'h01, 0, 0);   // R5 signed overflow on subtract
    run_op(3'd2, 8'hF0, 0, 0);   // R5 borrow
    run_op(3'd2, 8'h00, 0, 0);   // R5 borrow consumed
    run_op(3'd6, 8'hFF, 0, 0);
    run_op(3'd3, 8'h55, 0, 0);   // R6 increment wraps, operand ignored
    run_op(3'd6, 8'd200, 0, 0);
    run_op(3'd7, 8'd200, 0, 0);
    run_op(3'd4, 8'h00, 0, 0);   // R7 product above FFh
    run_op(3'd6, 8'd13, 0, 0);
    run_op(3'd7, 8'd7, 0, 0);
    run_op(3'd4, 8'h00, 0, 0);   // R7 small product
    run_op(3'd7, 8'd7, 0, 0);
    run_op(3'd5, 8'h00, 0, 0);   // R8 divide
    run_op(3'd7, 8'd0, 0, 0);
    run_op(3'd5, 8'h00, 0, 0);   // R8 divide by zero keeps A and B
    run_op(3'd6, 8'h11, 1, 7'b1011011); // R10 write with a load
    run_op(3'd1, 8'h22, 1, 7'b0110100); // R10 write colliding with add-with-carry
    run_op(3'd7, 8'h3C, 1, 7'b0001000); // R10 bank select 01

    for (int i = 0; i < 400; i++) begin
      logic [2:0] s;
      logic [7:0] v;
      bit w;
      s = 3'($urandom_range(0, 7));
      v = 8'($urandom);
      if ($urandom_range(0, 9) == 0) v = 8'h00;
      w = ($urandom_range(0, 7) == 0);
      run_op(s, v, w, 7'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule